// File: doc/BRIEF.md
# Center-Aligned PWM Time Base

This block is the timing heart of a three-phase pulse-width modulator. An up/down counter sweeps from zero up to one less than the active period value and then back down to zero. Each sweep takes twice the period value in clocks. A synchronization pulse opens every period. When the double-update mode is selected, a second pulse opens the falling half. The same clock edge that starts a sync pulse copies every staged setting into the active set. These settings are the period, the dead time, the minimum pulse width, the sync width and one duty value per phase.

Software-side logic writes staged settings through a single-cycle write port, at any time. A write has no effect on the outputs until the next latching edge. In single-update mode that edge comes only at the start of a period, so each phase's high-side command is symmetric about the mid-point. In double-update mode the settings can also change at the mid-point, which gives asymmetric patterns. A half-cycle flag tells which half of the period is in progress. The active dead time and minimum pulse width are only carried out to the downstream output stage.

Top module: `cpwm_timebase`

## Requirements
- R1: While reset is held, the count output is 0, the sync output is low, every high-side command is low, and the active period reads the reset-default period parameter. The first period begins on the first clock after reset is released.
- R2: With active period P, the count runs 0,1,…,P-1 with the half flag low, then P-1,…,1,0 with the half flag high. One period is 2·P clocks.
- R3: A period value of 1000 gives exactly 2000 clocks between period starts, which is 10 kHz at a 20 MHz clock.
- R4: In single-update mode there is exactly one sync rising edge per period. It falls in the first clock of the period, where the count is 0 and the half flag is low.
- R5: In double-update mode there is one more sync rising edge, in the first clock of the falling half. The staged values are latched there as well.
- R6: The mode bit is bit 0 of the word written to select 7 (0 = single-update, 1 = double-update). It takes effect right after the write and is 0 after reset.
- R7: Staged registers are written when the write enable is high, by select: 0 period, 1 dead time, 2 minimum pulse width, 3 sync width, 4/5/6 duty of phase 0/1/2. A staged write changes no output and no active value until the next latching sync edge, where all of them are copied together.
- R8: The sync output stays high for the active sync-width number of clocks. A width of 0 gives one clock.
- R9: A phase's high-side command is high exactly while the count is below that phase's active duty. A duty of 0 keeps it low, and a duty at or above the period keeps it high.
- R10: In single-update mode, each high-side command is high for the same number of clocks in the rising and falling halves.
- R11: A staged period of 0 is latched as 1, which gives a two-clock period with the count held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Staged-register write strobe |
| wr_sel | input | 3 | Staged-register select |
| wr_data | input | CNT_W | Write data, truncated to the field width |
| cnt_o | output | CNT_W | Up/down counter value |
| half_o | output | 1 | Low in the rising half, high in the falling half |
| sync_o | output | 1 | Synchronization pulse |
| act_per_o | output | CNT_W | Active period value |
| act_dt_o | output | DT_W | Active dead time |
| act_mpw_o | output | DT_W | Active minimum pulse width |
| act_sw_o | output | SW_W | Active sync width |
| act_duty_o | output | NPH*CNT_W | Active duty values, phase 0 in the low bits |
| pwm_hi_o | output | NPH | Raw high-side commands, one per phase |

## Verification
A counter that skips or repeats a value shows within one clock as a break in the 0…P-1, P-1…0 walk at the count output. It also shows as a period length other than 2·P at the next sync edge. A wrong latching decision shows as an active value or a high-side command that changes in the wrong half. Writing a duty inside a period and counting high clocks per half exposes such a leak within that same period. An error in the sync-width counter shows in the first pulse after the width is written, as a wrong number of high clocks.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
   typedef enum logic [2:0] {
      SEL_PER   = 3'd0,
      SEL_DT    = 3'd1,
      SEL_MPW   = 3'd2,
      SEL_SW    = 3'd3,
      SEL_DUTY0 = 3'd4,
      SEL_DUTY1 = 3'd5,
      SEL_DUTY2 = 3'd6,
      SEL_MODE  = 3'd7
   } cpwm_sel_e;

   localparam int MAX_PHASES = 3;
endpackage

// File: rtl/cpwm_shadow.sv
module cpwm_shadow
   import cpwm_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int DT_W    = 10,
   parameter int SW_W    = 8,
   parameter int NPH     = 3,
   parameter int RST_PER = 1000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [2:0]           wr_sel,
   input  logic [CNT_W-1:0]     wr_data,
   input  logic                 load,
   output logic [CNT_W-1:0]     act_per,
   output logic [DT_W-1:0]      act_dt,
   output logic [DT_W-1:0]      act_mpw,
   output logic [SW_W-1:0]      act_sw,
   output logic [NPH*CNT_W-1:0] act_duty,
   output logic [SW_W-1:0]      nxt_sw,
   output logic                 dbl_mode
);
   localparam logic [CNT_W-1:0] PER_RST = CNT_W'(RST_PER);
   localparam logic [CNT_W-1:0] PER_ONE = CNT_W'(1);

   logic [CNT_W-1:0] s_per;
   logic [DT_W-1:0]  s_dt, s_mpw;
   logic [SW_W-1:0]  s_sw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_per    <= PER_RST;
         s_dt     <= '0;
         s_mpw    <= '0;
         s_sw     <= SW_W'(1);
         dbl_mode <= 1'b0;
      end else if (wr_en) begin
         case (cpwm_sel_e'(wr_sel))
            SEL_PER:  s_per    <= wr_data;
            SEL_DT:   s_dt     <= wr_data[DT_W-1:0];
            SEL_MPW:  s_mpw    <= wr_data[DT_W-1:0];
            SEL_SW:   s_sw     <= wr_data[SW_W-1:0];
            SEL_MODE: dbl_mode <= wr_data[0];
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_per <= PER_RST;
         act_dt  <= '0;
         act_mpw <= '0;
         act_sw  <= SW_W'(1);
      end else if (load) begin
         act_per <= (s_per == '0) ? PER_ONE : s_per;
         act_dt  <= s_dt;
         act_mpw <= s_mpw;
         act_sw  <= s_sw;
      end
   end

   assign nxt_sw = s_sw;

   for (genvar p = 0; p < NPH; p++) begin : g_phase
      localparam logic [2:0] MY_SEL = 3'(int'(SEL_DUTY0) + p);
      logic [CNT_W-1:0] s_duty, a_duty;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          s_duty <= '0;
         else if (wr_en && wr_sel == MY_SEL)  s_duty <= wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    a_duty <= '0;
         else if (load) a_duty <= s_duty;
      end

      assign act_duty[p*CNT_W +: CNT_W] = a_duty;
   end
endmodule

// File: rtl/cpwm_updown.sv
module cpwm_updown #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] per,
   output logic [CNT_W-1:0] cnt,
   output logic             down,
   output logic             start_evt,
   output logic             mid_evt
);
   logic [CNT_W-1:0] top_val;

   assign top_val   = per - CNT_W'(1);
   assign mid_evt   = !down && (cnt >= top_val);
   assign start_evt = down && (cnt == '0);

   // reset parks in the falling half at zero so the first edge opens a period
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         down <= 1'b1;
      end else if (!down) begin
         if (mid_evt) down <= 1'b1;
         else         cnt  <= cnt + CNT_W'(1);
      end else begin
         if (start_evt) down <= 1'b0;
         else           cnt  <= cnt - CNT_W'(1);
      end
   end
endmodule

// File: rtl/cpwm_syncgen.sv
module cpwm_syncgen #(
   parameter int SW_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fire,
   input  logic [SW_W-1:0] width,
   output logic            sync
);
   logic [SW_W-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              left <= '0;
      else if (fire)           left <= (width == '0) ? SW_W'(1) : width;
      else if (left != '0)     left <= left - SW_W'(1);
   end

   assign sync = (left != '0);
endmodule

// File: rtl/cpwm_cmp.sv
module cpwm_cmp #(
   parameter int CNT_W = 16,
   parameter int NPH   = 3
) (
   input  logic [CNT_W-1:0]     cnt,
   input  logic [NPH*CNT_W-1:0] duty,
   output logic [NPH-1:0]       hi
);
   for (genvar p = 0; p < NPH; p++) begin : g_cmp
      assign hi[p] = (cnt < duty[p*CNT_W +: CNT_W]);
   end
endmodule

// File: rtl/cpwm_timebase.sv
module cpwm_timebase
   import cpwm_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int DT_W    = 10,
   parameter int SW_W    = 8,
   parameter int NPH     = 3,
   parameter int RST_PER = 1000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [2:0]           wr_sel,
   input  logic [CNT_W-1:0]     wr_data,
   output logic [CNT_W-1:0]     cnt_o,
   output logic                 half_o,
   output logic                 sync_o,
   output logic [CNT_W-1:0]     act_per_o,
   output logic [DT_W-1:0]      act_dt_o,
   output logic [DT_W-1:0]      act_mpw_o,
   output logic [SW_W-1:0]      act_sw_o,
   output logic [NPH*CNT_W-1:0] act_duty_o,
   output logic [NPH-1:0]       pwm_hi_o
);
   if (CNT_W < 2)                           begin : g_bad_cnt  $error("CNT_W too small");  end
   if (DT_W < 1 || DT_W > CNT_W)            begin : g_bad_dt   $error("DT_W out of range"); end
   if (SW_W < 1 || SW_W > CNT_W)            begin : g_bad_sw   $error("SW_W out of range"); end
   if (NPH < 1 || NPH > MAX_PHASES)         begin : g_bad_nph  $error("NPH out of range");  end
   if (RST_PER < 1 || RST_PER >= (1 << CNT_W)) begin : g_bad_per $error("RST_PER out of range"); end

   logic             start_evt, mid_evt, dbl_mode, load;
   logic [SW_W-1:0]  nxt_sw;

   assign load = start_evt || (mid_evt && dbl_mode);

   cpwm_shadow #(
      .CNT_W(CNT_W), .DT_W(DT_W), .SW_W(SW_W), .NPH(NPH), .RST_PER(RST_PER)
   ) u_shadow (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .load(load), .act_per(act_per_o), .act_dt(act_dt_o), .act_mpw(act_mpw_o),
      .act_sw(act_sw_o), .act_duty(act_duty_o), .nxt_sw(nxt_sw), .dbl_mode(dbl_mode)
   );

   cpwm_updown #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .per(act_per_o), .cnt(cnt_o), .down(half_o),
      .start_evt(start_evt), .mid_evt(mid_evt)
   );

   cpwm_syncgen #(.SW_W(SW_W)) u_sync (
      .clk(clk), .rst_n(rst_n), .fire(load), .width(nxt_sw), .sync(sync_o)
   );

   cpwm_cmp #(.CNT_W(CNT_W), .NPH(NPH)) u_cmp (
      .cnt(cnt_o), .duty(act_duty_o), .hi(pwm_hi_o)
   );
endmodule

// File: rtl/cpwm_timebase_chk.sv
module cpwm_timebase_chk #(
   parameter int CNT_W = 16,
   parameter int NPH   = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [CNT_W-1:0]     cnt_o,
   input logic                 half_o,
   input logic                 sync_o,
   input logic [NPH*CNT_W-1:0] act_duty_o,
   input logic                 dbl_mode,
   input logic                 load
);
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + CNT_W'(1)) ||
      (cnt_o == $past(cnt_o) - CNT_W'(1))); // R2

   AST_HALF_TURN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(half_o) |-> $stable(cnt_o)); // R2

   AST_SYNC_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(half_o) |-> (sync_o && cnt_o == '0)); // R4

   AST_SYNC_AT_MID: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(half_o) && $past(dbl_mode)) |-> sync_o); // R5

   AST_NO_MID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(half_o) && !$past(dbl_mode)) |-> !$rose(sync_o)); // R4

   AST_ACT_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_duty_o) |-> $past(load)); // R7
endmodule

bind cpwm_timebase cpwm_timebase_chk #(.CNT_W(CNT_W), .NPH(NPH)) u_chk (
   .clk(clk), .rst_n(rst_n), .cnt_o(cnt_o), .half_o(half_o), .sync_o(sync_o),
   .act_duty_o(act_duty_o), .dbl_mode(dbl_mode), .load(load)
);

// File: tb/sim_cpwm_timebase.sv
`timescale 1ns/1ps
module sim_cpwm_timebase;
   localparam int CNT_W = 16, DT_W = 10, SW_W = 8, NPH = 3, RST_PER = 8;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 wr_en = 1'b0;
   logic [2:0]           wr_sel = '0;
   logic [CNT_W-1:0]     wr_data = '0;
   logic [CNT_W-1:0]     cnt_o, act_per_o;
   logic                 half_o, sync_o;
   logic [DT_W-1:0]      act_dt_o, act_mpw_o;
   logic [SW_W-1:0]      act_sw_o;
   logic [NPH*CNT_W-1:0] act_duty_o;
   logic [NPH-1:0]       pwm_hi_o;

   int n_chk = 0, n_fail = 0;
   int m_len, m_rises, m_synchi, m_cnterr;
   int up_hi [NPH];
   int dn_hi [NPH];

   always #2 clk = ~clk;

   cpwm_timebase #(.CNT_W(CNT_W), .DT_W(DT_W), .SW_W(SW_W), .NPH(NPH), .RST_PER(RST_PER)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .cnt_o(cnt_o), .half_o(half_o), .sync_o(sync_o), .act_per_o(act_per_o),
      .act_dt_o(act_dt_o), .act_mpw_o(act_mpw_o), .act_sw_o(act_sw_o),
      .act_duty_o(act_duty_o), .pwm_hi_o(pwm_hi_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int sel, input int data);
      wr_en = 1'b1; wr_sel = 3'(sel); wr_data = CNT_W'(data);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_start();
      bit prev;
      prev = sync_o;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (sync_o && !prev && !half_o) return;
         prev = sync_o;
      end
      check(1'b0, "R4 start sync seen", 0, 1);
   endtask

   // starts at a start-of-period rise, ends at the next one
   task automatic measure(input int p, input int wk, input int wsel, input int wdat);
      bit prev;
      int k;
      m_len = 0; m_rises = 0; m_synchi = 0; m_cnterr = 0;
      for (int i = 0; i < NPH; i++) begin up_hi[i] = 0; dn_hi[i] = 0; end
      prev = 1'b0;
      k = 0;
      while (k < 5000) begin
         if (k > 0 && sync_o && !prev && !half_o) break;
         if (sync_o && !prev) m_rises++;
         if (sync_o) m_synchi++;
         if (int'(cnt_o) != ((k < p) ? k : 2*p-1-k)) m_cnterr++;
         if (half_o != (k >= p)) m_cnterr++;
         for (int i = 0; i < NPH; i++)
            if (pwm_hi_o[i]) begin
               if (half_o) dn_hi[i]++; else up_hi[i]++;
            end
         prev = sync_o;
         if (k == wk) begin wr_en = 1'b1; wr_sel = 3'(wsel); wr_data = CNT_W'(wdat); end
         else wr_en = 1'b0;
         @(negedge clk);
         k++;
      end
      wr_en = 1'b0;
      m_len = k;
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(cnt_o == 0, "R1 cnt", int'(cnt_o), 0);
      check(sync_o == 0, "R1 sync", int'(sync_o), 0);
      check(pwm_hi_o == 0, "R1 pwm", int'(pwm_hi_o), 0);
      check(act_per_o == RST_PER, "R1 period", int'(act_per_o), RST_PER);
      rst_n = 1'b1;
      @(negedge clk);
      check(sync_o == 1 && cnt_o == 0 && !half_o, "R1 first period start", int'(sync_o), 1);
   endtask

   task automatic t_single_basic();
      wr(0, 5); wr(3, 2); wr(4, 2); wr(5, 5); wr(6, 0);
      wait_start();
      check(act_per_o == 5, "R7 period latched", int'(act_per_o), 5);
      measure(5, -1, 0, 0);
      check(m_len == 10, "R2 period length", m_len, 10);
      check(m_cnterr == 0, "R2 count walk", m_cnterr, 0);
      check(m_rises == 1, "R4 R6 one sync per period", m_rises, 1);
      check(m_synchi == 2, "R8 sync width 2", m_synchi, 2);
      check(up_hi[0] == 2 && dn_hi[0] == 2, "R10 symmetric phase0", up_hi[0]*100+dn_hi[0], 202);
      check(up_hi[1] + dn_hi[1] == 10, "R9 duty at period stays high", up_hi[1]+dn_hi[1], 10);
      check(up_hi[2] + dn_hi[2] == 0, "R9 duty zero stays low", up_hi[2]+dn_hi[2], 0);
   endtask

   task automatic t_staged_hidden();
      measure(5, 2, 4, 3);
      check(up_hi[0] == 2 && dn_hi[0] == 2, "R7 staged duty not visible", up_hi[0]*100+dn_hi[0], 202);
      check(act_duty_o[CNT_W-1:0] == 3, "R7 duty latched at start", int'(act_duty_o[CNT_W-1:0]), 3);
      measure(5, -1, 0, 0);
      check(up_hi[0] == 3 && dn_hi[0] == 3, "R10 new duty symmetric", up_hi[0]*100+dn_hi[0], 303);
   endtask

   task automatic t_double();
      wr(7, 1);
      wait_start();
      measure(5, 1, 4, 4);
      check(m_rises == 2, "R5 R6 two syncs per period", m_rises, 2);
      check(m_synchi == 4, "R8 width 2 twice", m_synchi, 4);
      check(m_cnterr == 0 && m_len == 10, "R5 half flag and count", m_cnterr*100+m_len, 10);
      check(up_hi[0] == 3 && dn_hi[0] == 4, "R5 asymmetric mid reload", up_hi[0]*100+dn_hi[0], 304);
      wr(3, 0);
      wait_start();
      measure(5, -1, 0, 0);
      check(m_synchi == 2 && m_rises == 2, "R8 width 0 gives one clock", m_synchi, 2);
   endtask

   task automatic t_long();
      wr(0, 1000);
      wait_start();
      check(act_per_o == 1000, "R3 period 1000 latched", int'(act_per_o), 1000);
      measure(1000, -1, 0, 0);
      check(m_len == 2000 && m_rises == 2, "R3 R5 double mode 2000 clocks", m_len, 2000);
      wr(7, 0);
      wait_start();
      measure(1000, -1, 0, 0);
      check(m_len == 2000, "R3 period 2000 clocks", m_len, 2000);
      check(m_rises == 1, "R4 single mode one sync", m_rises, 1);
      check(m_cnterr == 0, "R2 long count walk", m_cnterr, 0);
      check(up_hi[1] == 5 && dn_hi[1] == 5, "R9 R10 duty 5 of 1000", up_hi[1]*100+dn_hi[1], 505);
   endtask

   task automatic t_zero_period();
      wr(0, 0);
      wait_start();
      check(act_per_o == 1, "R11 period 0 latched as 1", int'(act_per_o), 1);
      measure(1, -1, 0, 0);
      check(m_len == 2 && m_cnterr == 0, "R11 two-clock period", m_len, 2);
   endtask

   initial begin
      t_reset();
      t_single_basic();
      t_staged_hidden();
      t_double();
      t_long();
      t_zero_period();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(4 * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule